// File: doc/BRIEF.md
# Slave Bit-Count Error Detector

This block sits beside a synchronous serial port that takes its clock or its frame from an outside device. It counts down the bits of each word as active serial clock edges arrive. It flags an error when a new frame begins before that count has reached zero, which means the outside device started a word early.

The error is kept in a sticky status bit that software clears by writing one. An interrupt request is formed from the status bit and a mask input. The mask silences only the interrupt, so the status bit still records every early frame. When the port is master of its own clock and frame, the counter is held at zero and nothing is flagged.

The word length is applied on every frame start. After an early frame the counter reloads, so the next word is counted normally.

Top module: `bcnt_err_det`

## Requirements
- R1: After reset, `err_sts` and `irq` are 0.
- R2: With `slave_en` high, a frame start loads the counter with the word length. Each `sclk_edge` lowers it by one, down to zero. Further edges leave it at zero. A frame start that arrives when the counter is at zero raises no error.
- R3: With `slave_en` high, a frame start seen while the counter is not zero sets `err_sts` one clock later.
- R4: `err_sts` stays at 1 until a cycle with `clr_wr` high. That cycle clears it on the next clock.
- R5: `irq` is 1 exactly when `err_sts` is 1 and `irq_mask` is 0. A mask of 1 keeps `irq` at 0 while `err_sts` is still set.
- R6: The early frame start reloads the counter, so a full word counted after an error ends with no further error.
- R7: With `slave_en` low, the counter is held at zero and no frame start sets `err_sts`.
- R8: The word length is clamped to the range 4 to 16 before it is loaded. Values below 4 load 4, and values above 16 load 16.
- R9: When an error is detected in the same cycle as `clr_wr`, the error wins and `err_sts` is 1 on the next clock.
- R10: When a frame start and a serial clock edge come in the same cycle, the frame start takes effect and that edge is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slave_en | input | 1 | 1 when the port is a slave to its clock or frame |
| word_len | input | 5 | Configured bits per word (clamped to 4..16) |
| sclk_edge | input | 1 | One-cycle pulse per active serial clock edge |
| frame_start | input | 1 | One-cycle pulse per detected frame start |
| irq_mask | input | 1 | 1 blocks the interrupt for bit-count errors |
| clr_wr | input | 1 | Write-one-to-clear strobe for the status bit |
| err_sts | output | 1 | Sticky bit-count error status |
| irq | output | 1 | Interrupt request |

## Verification
`err_sts` is due one clock after the cycle in which the early frame start or the clear strobe is sampled. `irq` follows `err_sts` in that same cycle and tracks `irq_mask` with no added delay. The driver applies one cycle of stimulus at each falling edge and queues the output pair expected after the next rising edge. The monitor pops that entry 2 ns after the rising edge, so each comparison is made against the cycle in which the result is due.

// File: rtl/bcnt_err_det.sv
module bcnt_err_det #(
  parameter int LEN_W   = 5,
  parameter int MIN_LEN = 4,
  parameter int MAX_LEN = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slave_en,
  input  logic [LEN_W-1:0] word_len,
  input  logic             sclk_edge,
  input  logic             frame_start,
  input  logic             irq_mask,
  input  logic             clr_wr,
  output logic             err_sts,
  output logic             irq
);
  localparam int CNT_W = $clog2(MAX_LEN + 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] len_ld;
  logic             early;

  assign len_ld = (word_len < LEN_W'(MIN_LEN)) ? CNT_W'(MIN_LEN) :
                  (word_len > LEN_W'(MAX_LEN)) ? CNT_W'(MAX_LEN) :
                  CNT_W'(word_len);

  assign early = slave_en & frame_start & (cnt != '0);
  assign irq   = err_sts & ~irq_mask;

  always_ff @(posedge clk) begin
    if (!rst_n)                       cnt <= '0;
    else if (!slave_en)               cnt <= '0;
    else if (frame_start)             cnt <= len_ld;
    else if (sclk_edge && cnt != '0)  cnt <= cnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) err_sts <= 1'b0;
    else        err_sts <= early | (err_sts & ~clr_wr);
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n) cnt <= CNT_W'(MAX_LEN)); // R8
  AST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (slave_en && frame_start) |=> cnt == $past(len_ld)); // R6
  AST_EARLY_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (slave_en && frame_start && cnt != '0) |=> err_sts); // R3
  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err_sts && !clr_wr) |=> err_sts); // R4
  AST_MASTER_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!slave_en && !err_sts) |=> !err_sts); // R7
  AST_MASK_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    irq_mask |-> !irq); // R5
  AST_EDGE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (slave_en && frame_start && sclk_edge) |=> cnt == $past(len_ld)); // R10
endmodule

// File: tb/test_bcnt_err_det.sv
module test_bcnt_err_det;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic slave_en = 1'b0;
  logic [4:0] word_len = 5'd8;
  logic sclk_edge = 1'b0;
  logic frame_start = 1'b0;
  logic irq_mask = 1'b0;
  logic clr_wr = 1'b0;
  logic err_sts, irq;

  always #5 clk = ~clk;

  bcnt_err_det i_bcnt_err_det (
    .clk(clk), .rst_n(rst_n), .slave_en(slave_en), .word_len(word_len),
    .sclk_edge(sclk_edge), .frame_start(frame_start), .irq_mask(irq_mask),
    .clr_wr(clr_wr), .err_sts(err_sts), .irq(irq)
  );

  typedef struct {
    bit    e;
    bit    i;
    string tag;
  } exp_t;

  exp_t q[$];
  exp_t cur;
  int total = 0;
  int bad = 0;
  bit g_slv = 1'b0;
  bit g_msk = 1'b0;
  bit [4:0] g_wl = 5'd8;
  int m_cnt = 0;
  bit m_err = 1'b0;

  function automatic int clamp_len(input bit [4:0] wl);
    if (wl < 4) return 4;
    if (wl > 16) return 16;
    return int'(wl);
  endfunction

  task automatic step(input bit fs, input bit se, input bit clr, input string tag);
    exp_t x;
    bit evt;
    @(negedge clk);
    slave_en = g_slv; irq_mask = g_msk; word_len = g_wl;
    frame_start = fs; sclk_edge = se; clr_wr = clr;
    evt = g_slv && fs && (m_cnt != 0);
    if (!g_slv) m_cnt = 0;
    else if (fs) m_cnt = clamp_len(g_wl);
    else if (se && m_cnt != 0) m_cnt = m_cnt - 1;
    m_err = evt | (m_err & !clr);
    x.e = m_err; x.i = m_err & !g_msk; x.tag = tag;
    q.push_back(x);
  endtask

  task automatic edges(input int n, input string tag);
    for (int k = 0; k < n; k++) step(1'b0, 1'b1, 1'b0, tag);
  endtask

  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      cur = q.pop_front();
      total++;
      if (err_sts !== cur.e || irq !== cur.i) begin
        bad++;
        $display("FAIL %s: err_sts/irq actual=%b/%b expected=%b/%b",
                 cur.tag, err_sts, irq, cur.e, cur.i);
      end
    end
  end

  initial begin
    #1000000;
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #2;
    total++;
    if (err_sts !== 1'b0 || irq !== 1'b0) begin
      bad++;
      $display("FAIL R1: err_sts/irq actual=%b/%b expected=0/0", err_sts, irq);
    end

    g_slv = 1'b1; g_wl = 5'd8;
    step(1'b1, 1'b0, 1'b0, "R2");
    edges(8, "R2");
    edges(2, "R2");
    step(1'b1, 1'b0, 1'b0, "R2");
    edges(3, "R3");
    step(1'b1, 1'b0, 1'b0, "R3");
    step(1'b0, 1'b0, 1'b0, "R4");
    step(1'b0, 1'b0, 1'b0, "R4");
    step(1'b0, 1'b0, 1'b1, "R4");
    edges(8, "R6");
    step(1'b1, 1'b0, 1'b0, "R6");

    g_msk = 1'b1;
    edges(2, "R5");
    step(1'b1, 1'b0, 1'b0, "R5");
    step(1'b0, 1'b0, 1'b0, "R5");
    g_msk = 1'b0;
    step(1'b0, 1'b0, 1'b0, "R5");
    step(1'b0, 1'b0, 1'b1, "R4");

    edges(1, "R9");
    step(1'b1, 1'b0, 1'b1, "R9");
    step(1'b0, 1'b0, 1'b1, "R9");

    g_slv = 1'b0;
    step(1'b1, 1'b0, 1'b0, "R7");
    step(1'b1, 1'b1, 1'b0, "R7");
    step(1'b1, 1'b0, 1'b0, "R7");

    g_slv = 1'b1; g_wl = 5'd2;
    step(1'b1, 1'b0, 1'b0, "R8");
    edges(3, "R8");
    step(1'b1, 1'b0, 1'b0, "R8");
    step(1'b0, 1'b0, 1'b1, "R8");
    edges(4, "R8");
    step(1'b1, 1'b0, 1'b0, "R8");
    g_wl = 5'd20;
    edges(16, "R8");
    step(1'b1, 1'b0, 1'b0, "R8");
    edges(15, "R8");
    step(1'b1, 1'b0, 1'b0, "R8");
    step(1'b0, 1'b0, 1'b1, "R8");

    g_wl = 5'd4;
    step(1'b1, 1'b0, 1'b0, "R10");
    edges(3, "R10");
    step(1'b1, 1'b1, 1'b0, "R10");
    step(1'b0, 1'b0, 1'b1, "R10");
    edges(3, "R10");
    step(1'b1, 1'b0, 1'b0, "R10");
    step(1'b0, 1'b0, 1'b0, "R10");

    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule